// File: doc/BRIEF.md
# NAND Step Hamming ECC Engine

This block builds a single-error-correcting Hamming code over a NAND page while the page streams through a 32-bit data register. The page is cut into steps of 256 bytes. For each step the engine folds every byte into a 22-bit raw parity word. That word holds sixteen line bits taken from the byte position and six column bits taken from the bit position inside the byte. When the last byte of a step arrives, the word is stored in one of eight slots and a one-cycle ready pulse is raised. A DMA master then fetches the word. A small page uses two slots and a large page uses all eight.

A read port returns the raw word for any slot, together with its packed 24-bit spare-area form. The packed form is the raw word moved up two places, inverted and cut to 24 bits. A separate checker takes a stored and a recomputed packed code for one step. It decides whether the step is clean, has one flipped data bit (and gives its byte and bit position), has an error in the code bytes themselves, or cannot be repaired. It also keeps a running count of repairs and a sticky flag for unrepairable steps.

Top module: `nand_step_ecc`

## Requirements
- R1: After a synchronous active-low reset, `step_ready`, `step_overrun`, `chk_done`, `chk_corr_total` and `chk_uncorrectable` are 0, and every slot reads back as 0 on `ecc_rd_raw`.
- R2: In word mode each accepted beat carries four bytes of the step. Byte lane 0 (`dat_word[7:0]`) has the lowest byte index, and a step starts at index 0. Raw bit 2k is the XOR of the byte parities of all bytes whose index bit k is 0, and raw bit 2k+1 is the same for index bit k equal to 1, for k = 0..7.
- R3: Raw bits 16+2j and 17+2j are the XOR, over the whole step, of all data bits whose bit position has bit j at 0 and at 1 respectively, for j = 0..2. `ecc_rd_raw` returns the 22-bit word zero-extended to 32 bits.
- R4: With `cfg_byte_mode` high, each accepted beat carries one byte in `dat_word[7:0]`, and bits [31:8] have no effect.
- R5: The beat that completes byte 256 of a step stores the word in the current slot. The slot pointer starts at 0 after reset or clear and wraps after slot 7. `step_ready` is high for exactly the one cycle after that beat.
- R6: A beat offered while `cfg_ecc_en` is low is ignored: it adds no bytes and no parity.
- R7: A cycle with `ctl_ecc_clr` high discards the partial step, returns the slot pointer to 0, and clears the pending-fetch state and `step_overrun`. A beat offered in that cycle is dropped.
- R8: `ecc_rd_packed` equals the bitwise inverse of the raw word shifted left by two, taken to 24 bits. Bits [23:16] are the spare byte at the lowest offset, then [15:8], then [7:0].
- R9: A completed step leaves a word pending until `ecc_rd_ack` is seen with `cfg_dma_ecc` high. If a step completes while a word is still pending and no such fetch is present in that cycle, `step_overrun` is set and holds until a clear.
- R10: One cycle after `chk_valid`, `chk_done` is high. If the stored and calculated codes are equal, `chk_class` is 0 (clean).
- R11: If the raw part of the syndrome (`chk_stored ^ chk_calc`, bits [23:2]) has exactly one bit set in every pair and bits [1:0] are clear, then `chk_class` is 1. In that case `chk_fix_byte` is the set odd bits of the line pairs, `chk_fix_mask` has a single 1 at the bit given by the odd column bits, and `chk_corr_total` rises by one.
- R12: A syndrome with exactly one bit set gives `chk_class` 2 (error in the code bytes), leaves `chk_fix_mask` at 0, and adds one to `chk_corr_total`.
- R13: Any other non-zero syndrome gives `chk_class` 3 and sets `chk_uncorrectable`, which stays set until `chk_start`. `chk_start` zeroes the count and the flag. The count stops at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ecc_en | input | 1 | Accept data beats into the parity |
| cfg_dma_ecc | input | 1 | Let `ecc_rd_ack` count as a fetch |
| cfg_byte_mode | input | 1 | One byte per beat in bits [7:0] |
| ctl_ecc_clr | input | 1 | Clear the partial step, pointer and flags |
| dat_valid | input | 1 | Data beat present |
| dat_word | input | 32 | Data beat, lane 0 lowest byte |
| step_ready | output | 1 | One-cycle pulse after a step finishes |
| step_overrun | output | 1 | Sticky: a step finished over an unfetched word |
| ecc_rd_idx | input | 3 | Slot to read |
| ecc_rd_ack | input | 1 | Fetch of the pending word |
| ecc_rd_raw | output | 32 | Raw parity word of the chosen slot |
| ecc_rd_packed | output | 24 | Packed spare-area code of the chosen slot |
| chk_start | input | 1 | Zero the checker totals |
| chk_valid | input | 1 | Compare one step |
| chk_stored | input | 24 | Code read from the spare area |
| chk_calc | input | 24 | Code recomputed from the data |
| chk_done | output | 1 | Result valid |
| chk_class | output | 2 | 0 clean, 1 data fix, 2 code fix, 3 fail |
| chk_fix_byte | output | 8 | Byte index of the bad bit |
| chk_fix_mask | output | 8 | One-hot flip mask for that byte |
| chk_corr_total | output | 8 | Repairs since `chk_start` (saturates) |
| chk_uncorrectable | output | 1 | Sticky: a step could not be repaired |

## Verification
The bench targets several boundaries. The first is the exact beat that closes a step, in both word and byte mode. Counting lanes wrong, or raising ready on the wrong cycle, would move or drop the pulse and shift every later word. Beats offered while accumulation is off are mixed into a step, so a design that still counted them would store the wrong parity. Other cases check the pointer wrap after eight steps and the reset of the pointer by a clear, which a flaw would show by writing to the wrong slot. They also cover a fetch made while fetching is disabled, which must not stop the overrun flag. The checker gets a data flip, single flips in the high and low bits of the code, and a double flip in one byte. A design that mixed up pair counting with bit counting would then mislabel a step or flip the wrong bit.

// File: rtl/nand_ecc_pkg.sv
// Shared constants, result encoding and small pure functions of the step ECC engine.
package nand_ecc_pkg;
    localparam int ECC_IDX_W      = 8;                  // byte index width inside one step
    localparam int ECC_LANES      = 4;                  // bytes per word beat
    localparam int ECC_MAX_STEPS  = 8;                  // parity words held
    localparam int ECC_STEP_BYTES = 1 << ECC_IDX_W;
    localparam int ECC_COL_W      = 6;                  // three column pairs
    localparam int ECC_LINE_W     = 2 * ECC_IDX_W;      // one pair per index bit
    localparam int ECC_RAW_W      = ECC_LINE_W + ECC_COL_W;
    localparam int ECC_PK_W       = ECC_RAW_W + 2;
    localparam int ECC_NPAIR      = ECC_RAW_W / 2;

    typedef enum logic [1:0] {
        CHK_CLEAN    = 2'd0,
        CHK_DATA_FIX = 2'd1,
        CHK_ECC_FIX  = 2'd2,
        CHK_FAIL     = 2'd3
    } chk_class_e;

    // Column pairs from the XOR of all bytes: even bit for position bit j = 0, odd for 1.
    function automatic logic [ECC_COL_W-1:0] col_pairs(input logic [7:0] cx);
        logic [ECC_COL_W-1:0] r;
        r = '0;
        for (int bb = 0; bb < 8; bb++) begin
            for (int j = 0; j < 3; j++) begin
                if (((bb >> j) & 1) == 1) r[2*j+1] = r[2*j+1] ^ cx[bb];
                else                      r[2*j]   = r[2*j]   ^ cx[bb];
            end
        end
        return r;
    endfunction

    // Spare-area form: raw moved up two places and inverted.
    function automatic logic [ECC_PK_W-1:0] pack_raw(input logic [ECC_RAW_W-1:0] raw);
        return ~{raw, 2'b00};
    endfunction
endpackage

// File: rtl/ecc_line_accum.sv
// Folds the bytes of one step into line and column parity.
// Assumes: word mode is not mixed with byte mode inside a step, so in word
// mode the byte count stays a multiple of LANES. done and fin_raw are
// combinational and valid in the cycle of the closing beat.
module ecc_line_accum
    import nand_ecc_pkg::*;
#(
    parameter int LANES = ECC_LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 take,
    input  logic                 byte_mode,
    input  logic [8*LANES-1:0]   word,
    output logic                 done,
    output logic [ECC_RAW_W-1:0] fin_raw
);
    localparam int CW = ECC_IDX_W + 1;

    logic [ECC_IDX_W-1:0]  cnt;
    logic [ECC_LINE_W-1:0] line_acc, nxt_line;
    logic [7:0]            col_acc, nxt_col;
    logic [CW-1:0]         sum;
    logic [7:0]            b;
    logic [ECC_IDX_W-1:0]  idx;
    logic                  p;

    // Add the bytes of this beat into next-state parity.
    always_comb begin
        nxt_line = line_acc;
        nxt_col  = col_acc;
        b = '0;
        idx = '0;
        p = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (l == 0 || !byte_mode) begin
                b   = word[8*l +: 8];
                idx = cnt + ECC_IDX_W'(l);
                p   = ^b;
                for (int k = 0; k < ECC_IDX_W; k++) begin
                    if (idx[k]) nxt_line[2*k+1] = nxt_line[2*k+1] ^ p;
                    else        nxt_line[2*k]   = nxt_line[2*k]   ^ p;
                end
                nxt_col = nxt_col ^ b;
            end
        end
    end

    // Byte count after this beat; the carry marks the end of the step.
    always_comb begin
        sum     = {1'b0, cnt} + (byte_mode ? CW'(1) : CW'(LANES));
        done    = take & sum[ECC_IDX_W];
        fin_raw = {col_pairs(nxt_col), nxt_line};
    end

    // Hold the partial step; start over at the end of a step or on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt      <= '0;
            line_acc <= '0;
            col_acc  <= '0;
        end else if (take) begin
            cnt <= sum[ECC_IDX_W-1:0];
            if (sum[ECC_IDX_W]) begin
                line_acc <= '0;
                col_acc  <= '0;
            end else begin
                line_acc <= nxt_line;
                col_acc  <= nxt_col;
            end
        end
    end

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clr) |=> ($stable(cnt) && $stable(line_acc) && $stable(col_acc)));
    p_clear_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && line_acc == '0 && col_acc == '0));
endmodule

// File: rtl/ecc_step_store.sv
// Holds one raw parity word per step and tracks whether the last word was fetched.
// Assumes: done comes from the accumulator in the cycle of the closing beat;
// ack is already gated by the fetch enable.
module ecc_step_store
    import nand_ecc_pkg::*;
#(
    parameter int MAX_STEPS = ECC_MAX_STEPS,
    localparam int SLOT_W   = $clog2(MAX_STEPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 done,
    input  logic [ECC_RAW_W-1:0] fin_raw,
    input  logic                 ack,
    input  logic [SLOT_W-1:0]    rd_idx,
    output logic                 ready,
    output logic                 overrun,
    output logic [ECC_RAW_W-1:0] rd_raw
);
    logic [ECC_RAW_W-1:0] slots [MAX_STEPS];
    logic [SLOT_W-1:0]    ptr;
    logic                 pending;

    // Write the finished word into the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < MAX_STEPS; s++) slots[s] <= '0;
        end else if (done && !clr) begin
            slots[ptr] <= fin_raw;
        end
    end

    // Pointer, ready pulse, pending fetch and sticky overrun.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr     <= '0;
            ready   <= 1'b0;
            pending <= 1'b0;
            overrun <= 1'b0;
        end else begin
            ready <= done;
            if (done) begin
                ptr     <= (ptr == SLOT_W'(MAX_STEPS-1)) ? '0 : ptr + 1'b1;
                overrun <= overrun | (pending & ~ack);
                pending <= 1'b1;
            end else if (ack) begin
                pending <= 1'b0;
            end
        end
    end

    // Read port for the fetching master.
    always_comb begin
        rd_raw = (int'(rd_idx) < MAX_STEPS) ? slots[rd_idx] : '0;
    end

    p_ready_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr) |=> overrun);
    p_no_false_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!overrun && !pending && !clr) |=> !overrun);
endmodule

// File: rtl/ecc_syndrome_check.sv
// Compares a stored and a recomputed packed code for one step and classifies
// the difference; it gives the byte and bit to flip and keeps running totals.
// Assumes: codes use the packed layout of nand_ecc_pkg::pack_raw.
module ecc_syndrome_check
    import nand_ecc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                valid,
    input  logic [ECC_PK_W-1:0] stored,
    input  logic [ECC_PK_W-1:0] calc,
    output logic                done,
    output chk_class_e          cls,
    output logic [7:0]          fix_byte,
    output logic [7:0]          fix_mask,
    output logic [CNT_W-1:0]    corr_total,
    output logic                uncorr
);
    logic [ECC_PK_W-1:0]  syn;
    logic [ECC_RAW_W-1:0] rsyn;
    logic [ECC_NPAIR-1:0] pair_one;
    logic [ECC_IDX_W-1:0] loc_byte;
    logic [2:0]           loc_bit;
    chk_class_e           cls_c;

    assign syn  = stored ^ calc;
    assign rsyn = syn[ECC_PK_W-1:2];

    // One flag per parity pair: exactly one of its two bits differs.
    for (genvar g = 0; g < ECC_NPAIR; g++) begin : g_pair
        assign pair_one[g] = rsyn[2*g] ^ rsyn[2*g+1];
    end
    for (genvar k = 0; k < ECC_IDX_W; k++) begin : g_loc_byte
        assign loc_byte[k] = rsyn[2*k+1];
    end
    for (genvar j = 0; j < 3; j++) begin : g_loc_bit
        assign loc_bit[j] = rsyn[ECC_LINE_W + 2*j + 1];
    end

    // Classify the syndrome.
    always_comb begin
        if (syn == '0)                                cls_c = CHK_CLEAN;
        else if ((&pair_one) && syn[1:0] == 2'b00)    cls_c = CHK_DATA_FIX;
        else if ($countones(syn) == 1)                cls_c = CHK_ECC_FIX;
        else                                          cls_c = CHK_FAIL;
    end

    // Register the result and update the totals.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            done       <= 1'b0;
            cls        <= CHK_CLEAN;
            fix_byte   <= '0;
            fix_mask   <= '0;
            corr_total <= '0;
            uncorr     <= 1'b0;
        end else begin
            done <= valid;
            if (valid) begin
                cls      <= cls_c;
                fix_byte <= (cls_c == CHK_DATA_FIX) ? loc_byte : '0;
                fix_mask <= (cls_c == CHK_DATA_FIX) ? (8'd1 << loc_bit) : '0;
                if ((cls_c == CHK_DATA_FIX || cls_c == CHK_ECC_FIX) && !(&corr_total))
                    corr_total <= corr_total + 1'b1;
                if (cls_c == CHK_FAIL) uncorr <= 1'b1;
            end
        end
    end

    p_result_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !start) |=> done);
    p_fix_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cls == CHK_DATA_FIX) |-> ($countones(fix_mask) == 1));
    p_mask_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cls != CHK_DATA_FIX) |-> (fix_mask == '0));
    p_uncorr_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (uncorr && !start) |=> uncorr);
endmodule

// File: rtl/nand_step_ecc.sv
// Top of the step ECC engine: per-step parity over a streamed page, eight
// parity slots with packed read-out, and a single-bit syndrome checker.
// Assumes: the bus timing and the DMA master live outside; one word or one
// byte per accepted beat.
module nand_step_ecc
    import nand_ecc_pkg::*;
#(
    parameter int LANES     = ECC_LANES,
    parameter int MAX_STEPS = ECC_MAX_STEPS,
    parameter int CNT_W     = 8,
    localparam int DW       = 8 * LANES,
    localparam int SLOT_W   = $clog2(MAX_STEPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_ecc_en,
    input  logic                cfg_dma_ecc,
    input  logic                cfg_byte_mode,
    input  logic                ctl_ecc_clr,
    input  logic                dat_valid,
    input  logic [DW-1:0]       dat_word,
    output logic                step_ready,
    output logic                step_overrun,
    input  logic [SLOT_W-1:0]   ecc_rd_idx,
    input  logic                ecc_rd_ack,
    output logic [31:0]         ecc_rd_raw,
    output logic [ECC_PK_W-1:0] ecc_rd_packed,
    input  logic                chk_start,
    input  logic                chk_valid,
    input  logic [ECC_PK_W-1:0] chk_stored,
    input  logic [ECC_PK_W-1:0] chk_calc,
    output logic                chk_done,
    output logic [1:0]          chk_class,
    output logic [7:0]          chk_fix_byte,
    output logic [7:0]          chk_fix_mask,
    output logic [CNT_W-1:0]    chk_corr_total,
    output logic                chk_uncorrectable
);
    logic                 take, step_done, fetch;
    logic [ECC_RAW_W-1:0] fin_raw, slot_raw;
    chk_class_e           cls;

    assign take  = dat_valid & cfg_ecc_en;
    assign fetch = ecc_rd_ack & cfg_dma_ecc;

    ecc_line_accum #(.LANES(LANES)) u_accum (
        .clk(clk), .rst_n(rst_n), .clr(ctl_ecc_clr), .take(take),
        .byte_mode(cfg_byte_mode), .word(dat_word),
        .done(step_done), .fin_raw(fin_raw)
    );

    ecc_step_store #(.MAX_STEPS(MAX_STEPS)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(ctl_ecc_clr), .done(step_done),
        .fin_raw(fin_raw), .ack(fetch), .rd_idx(ecc_rd_idx),
        .ready(step_ready), .overrun(step_overrun), .rd_raw(slot_raw)
    );

    ecc_syndrome_check #(.CNT_W(CNT_W)) u_check (
        .clk(clk), .rst_n(rst_n), .start(chk_start), .valid(chk_valid),
        .stored(chk_stored), .calc(chk_calc), .done(chk_done), .cls(cls),
        .fix_byte(chk_fix_byte), .fix_mask(chk_fix_mask),
        .corr_total(chk_corr_total), .uncorr(chk_uncorrectable)
    );

    // Read-out: raw word zero-extended, and its spare-area form.
    assign ecc_rd_raw    = {{(32-ECC_RAW_W){1'b0}}, slot_raw};
    assign ecc_rd_packed = pack_raw(slot_raw);
    assign chk_class     = cls;

    p_ready_after_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_ecc_clr |=> (!step_ready && !step_overrun));
endmodule

// File: tb/sim_nand_step_ecc.sv
// Self-checking bench: behavioural reference model updated on each rising edge,
// compared on each falling edge, plus directed checks on read-out and checker.
module sim_nand_step_ecc;
    import nand_ecc_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cfg_ecc_en = 1'b0, cfg_dma_ecc = 1'b0, cfg_byte_mode = 1'b0, ctl_ecc_clr = 1'b0;
    logic        dat_valid = 1'b0;
    logic [31:0] dat_word = '0;
    logic        step_ready, step_overrun;
    logic [2:0]  ecc_rd_idx = '0;
    logic        ecc_rd_ack = 1'b0;
    logic [31:0] ecc_rd_raw;
    logic [23:0] ecc_rd_packed;
    logic        chk_start = 1'b0, chk_valid = 1'b0;
    logic [23:0] chk_stored = '0, chk_calc = '0;
    logic        chk_done;
    logic [1:0]  chk_class;
    logic [7:0]  chk_fix_byte, chk_fix_mask, chk_corr_total;
    logic        chk_uncorrectable;

    nand_step_ecc u0 (
        .clk(clk), .rst_n(rst_n), .cfg_ecc_en(cfg_ecc_en), .cfg_dma_ecc(cfg_dma_ecc),
        .cfg_byte_mode(cfg_byte_mode), .ctl_ecc_clr(ctl_ecc_clr), .dat_valid(dat_valid),
        .dat_word(dat_word), .step_ready(step_ready), .step_overrun(step_overrun),
        .ecc_rd_idx(ecc_rd_idx), .ecc_rd_ack(ecc_rd_ack), .ecc_rd_raw(ecc_rd_raw),
        .ecc_rd_packed(ecc_rd_packed), .chk_start(chk_start), .chk_valid(chk_valid),
        .chk_stored(chk_stored), .chk_calc(chk_calc), .chk_done(chk_done),
        .chk_class(chk_class), .chk_fix_byte(chk_fix_byte), .chk_fix_mask(chk_fix_mask),
        .chk_corr_total(chk_corr_total), .chk_uncorrectable(chk_uncorrectable)
    );

    int n_chk = 0, n_fail = 0;
    bit fin = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference parity: walk every byte and every bit of the step.
    function automatic logic [21:0] ref_raw(input logic [7:0] bq[$]);
        logic [7:0] le = '0, lo = '0;
        logic [2:0] ce = '0, co = '0;
        logic [21:0] r;
        for (int i = 0; i < 256; i++) begin
            logic pb;
            pb = ^bq[i];
            for (int k = 0; k < 8; k++)
                if (((i >> k) & 1) == 1) lo[k] ^= pb; else le[k] ^= pb;
            for (int bb = 0; bb < 8; bb++)
                for (int j = 0; j < 3; j++)
                    if (((bb >> j) & 1) == 1) co[j] ^= bq[i][bb]; else ce[j] ^= bq[i][bb];
        end
        for (int k = 0; k < 8; k++) begin r[2*k] = le[k]; r[2*k+1] = lo[k]; end
        for (int j = 0; j < 3; j++) begin r[16+2*j] = ce[j]; r[17+2*j] = co[j]; end
        return r;
    endfunction

    function automatic logic [23:0] ref_pack(input logic [21:0] r);
        logic [23:0] t;
        t = {r, 2'b00};
        return ~t;
    endfunction

    // Reference model of step completion, slots, pending and overrun.
    logic [7:0]  mq[$];
    logic [21:0] m_slot [8];
    int          m_ptr = 0;
    bit          m_pend = 0, m_over = 0, m_ready = 0, m_dn = 0, m_ak = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_ptr = 0; m_pend = 0; m_over = 0; m_ready = 0;
            for (int s = 0; s < 8; s++) m_slot[s] = '0;
        end else begin
            m_ready = 0;
            m_dn = 0;
            m_ak = ecc_rd_ack && cfg_dma_ecc;
            if (ctl_ecc_clr) begin
                mq.delete();
                m_ptr = 0; m_pend = 0; m_over = 0;
            end else begin
                if (dat_valid && cfg_ecc_en) begin
                    for (int n = 0; n < (cfg_byte_mode ? 1 : 4); n++) mq.push_back(dat_word[8*n +: 8]);
                    if (mq.size() == 256) begin
                        m_slot[m_ptr] = ref_raw(mq);
                        m_ptr = (m_ptr + 1) % 8;
                        mq.delete();
                        m_dn = 1;
                    end
                end
                if (m_dn) begin
                    if (m_pend && !m_ak) m_over = 1;
                    m_pend = 1;
                    m_ready = 1;
                end else if (m_ak) m_pend = 0;
            end
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk(step_ready === m_ready, "R5 ready pulse", 32'(step_ready), 32'(m_ready));
            chk(step_overrun === m_over, "R9 overrun flag", 32'(step_overrun), 32'(m_over));
        end
    end

    task automatic beat(input bit v, input bit en, input logic [31:0] w);
        @(negedge clk);
        dat_valid = v; cfg_ecc_en = en; dat_word = w;
    endtask

    task automatic idle();
        @(negedge clk);
        dat_valid = 1'b0; cfg_ecc_en = 1'b1;
    endtask

    // One word-mode step; kind 0 gives bytes equal to their index.
    task automatic word_step(input int kind);
        cfg_byte_mode = 1'b0;
        for (int w = 0; w < 64; w++) begin
            if (kind != 0 && ($urandom % 7) == 0) beat(1'b0, 1'b1, $urandom);
            if (kind == 0) beat(1'b1, 1'b1, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
            else           beat(1'b1, 1'b1, $urandom);
        end
        idle();
    endtask

    // One byte-mode step with ignored disabled beats mixed in.
    task automatic byte_step();
        @(negedge clk);
        cfg_byte_mode = 1'b1;
        for (int i = 0; i < 256; i++) begin
            if (($urandom % 4) == 0) beat(1'b1, 1'b0, $urandom);
            beat(1'b1, 1'b1, $urandom);
        end
        idle();
        cfg_byte_mode = 1'b0;
    endtask

    task automatic fetch();
        @(negedge clk); ecc_rd_ack = 1'b1;
        @(negedge clk); ecc_rd_ack = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk); ctl_ecc_clr = 1'b1;
        @(negedge clk); ctl_ecc_clr = 1'b0;
    endtask

    task automatic read_slot(input int s, input string tag);
        logic [23:0] pk;
        @(negedge clk);
        ecc_rd_idx = 3'(s);
        #1;
        pk = ref_pack(m_slot[s]);
        chk(ecc_rd_raw == {10'b0, m_slot[s]}, tag, ecc_rd_raw, {10'b0, m_slot[s]});
        chk(ecc_rd_packed == pk, "R8 packed code", 32'(ecc_rd_packed), 32'(pk));
        chk(ecc_rd_packed[23:16] == pk[23:16], "R8 first spare byte", 32'(ecc_rd_packed[23:16]), 32'(pk[23:16]));
    endtask

    task automatic run_chk(input logic [23:0] st, input logic [23:0] ca, input logic [1:0] ecls,
                           input logic [7:0] ebyte, input logic [7:0] emask, input string tag);
        @(negedge clk);
        chk_stored = st; chk_calc = ca; chk_valid = 1'b1;
        @(negedge clk);
        chk_valid = 1'b0;
        chk(chk_done == 1'b1, "R10 done next cycle", 32'(chk_done), 32'd1);
        chk(chk_class == ecls, tag, 32'(chk_class), 32'(ecls));
        chk(chk_fix_mask == emask, tag, 32'(chk_fix_mask), 32'(emask));
        if (ecls == 2'd1) chk(chk_fix_byte == ebyte, tag, 32'(chk_fix_byte), 32'(ebyte));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (R1-R13 run) actual=timeout expected=finish");
        fin = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  buf0[$], buf1[$], buf2[$];
        logic [21:0] r0, r1, r2;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(step_ready == 1'b0, "R1 ready", 32'(step_ready), 0);
        chk(step_overrun == 1'b0, "R1 overrun", 32'(step_overrun), 0);
        chk(ecc_rd_raw == 32'd0, "R1 slot zero", ecc_rd_raw, 0);
        chk(chk_done == 1'b0 && chk_uncorrectable == 1'b0, "R1 checker", 32'({chk_done, chk_uncorrectable}), 0);
        chk(chk_corr_total == 8'd0, "R1 total", 32'(chk_corr_total), 0);
        rst_n = 1'b1; cfg_dma_ecc = 1'b1; cfg_ecc_en = 1'b1;

        // R2 R3: word mode, index-valued bytes
        word_step(0);
        read_slot(0, "R2 R3 word step parity");
        fetch();
        // R4 R6: byte mode with disabled beats
        byte_step();
        read_slot(1, "R4 R6 byte step parity");
        fetch();
        // R9: two steps without fetch
        word_step(1);
        read_slot(2, "R2 random word step");
        word_step(1);
        chk(step_overrun == 1'b1, "R9 overrun set", 32'(step_overrun), 1);
        // R7: clear resets flags and pointer
        clear();
        chk(step_overrun == 1'b0, "R7 overrun cleared", 32'(step_overrun), 0);
        cfg_dma_ecc = 1'b0;
        word_step(1);
        read_slot(0, "R7 pointer back to slot 0");
        fetch();
        cfg_dma_ecc = 1'b1;
        word_step(1);
        chk(step_overrun == 1'b1, "R9 fetch ignored when disabled", 32'(step_overrun), 1);
        // R5: wrap after eight slots
        clear();
        for (int s = 0; s < 9; s++) begin word_step(1); fetch(); end
        read_slot(0, "R5 wrap rewrites slot 0");
        read_slot(7, "R5 last slot");
        chk(step_overrun == 1'b0, "R9 no overrun with fetches", 32'(step_overrun), 0);

        // Checker cases
        for (int i = 0; i < 256; i++) buf0.push_back(8'($urandom));
        buf1 = buf0; buf1[77][5] = ~buf1[77][5];
        buf2 = buf0; buf2[10][1] = ~buf2[10][1]; buf2[10][6] = ~buf2[10][6];
        r0 = ref_raw(buf0); r1 = ref_raw(buf1); r2 = ref_raw(buf2);
        @(negedge clk); chk_start = 1'b1;
        @(negedge clk); chk_start = 1'b0;
        run_chk(ref_pack(r0), ref_pack(r0), 2'd0, 8'd0, 8'd0, "R10 clean step");
        run_chk(ref_pack(r0), ref_pack(r1), 2'd1, 8'd77, 8'h20, "R11 data bit fix");
        run_chk(ref_pack(r0) ^ 24'h000200, ref_pack(r0), 2'd2, 8'd0, 8'd0, "R12 code bit flip");
        run_chk(ref_pack(r0) ^ 24'h000001, ref_pack(r0), 2'd2, 8'd0, 8'd0, "R12 low code bit flip");
        run_chk(ref_pack(r0), ref_pack(r2), 2'd3, 8'd0, 8'd0, "R13 double flip");
        chk(chk_uncorrectable == 1'b1, "R13 flag set", 32'(chk_uncorrectable), 1);
        chk(chk_corr_total == 8'd3, "R13 total", 32'(chk_corr_total), 3);
        run_chk(ref_pack(r1), ref_pack(r1), 2'd0, 8'd0, 8'd0, "R10 clean after fail");
        chk(chk_uncorrectable == 1'b1, "R13 flag sticky", 32'(chk_uncorrectable), 1);
        @(negedge clk); chk_start = 1'b1;
        @(negedge clk); chk_start = 1'b0;
        chk(chk_uncorrectable == 1'b0 && chk_corr_total == 8'd0, "R13 start clears",
            32'({chk_uncorrectable, chk_corr_total}), 0);

        fin = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule